// File: doc/BRIEF.md
# Spare-Row Remapping CAM

This block sits in front of the row decoder of a memory that has a small set of spare rows. While a self-test pass runs, the test controller reports each row that fails through a capture port. The block gives each newly reported row the next free spare, in strictly rising order: the first fault gets spare 0, the next gets spare 1, and so on. On every access it compares the incoming row address with all stored entries at once. On a hit it sends the access to the assigned spare row. On a miss it passes the address through unchanged. Column selection is not touched, so only the row is replaced.

An address names either a regular row or a spare row. A spare row is named by setting the spare flag, and its index is taken from the low bits of the row field. A spare that fails on a later pass can itself be captured. It then gets a higher spare, and every access that used to land on it moves to the new spare. Chains of failed spares therefore resolve in one lookup. When more new faults arrive than there are spares, a sticky overflow flag reports that repair cannot succeed. A failed column produces this same result, because it fills all the spares.

Top module: `srm_remap`

## Requirements
- R1: After reset, no entry is valid, `remap_hit` is 0 for every address and `overflow` is 0. Reset clears any earlier captures.
- R2: On a miss, `out_spare` equals `lk_spare`, `out_row` equals `lk_row` and `remap_hit` is 0. This holds for both regular and spare addresses.
- R3: A capture becomes visible at the first rising clock edge after `cap_en` is sampled high. A lookup of that address in the same cycle as its capture still misses. After the edge the lookup hits with `remap_hit`=1 and `out_spare`=1, and `out_row` carries the spare index, zero-extended.
- R4: New faults receive spare indices in strictly increasing order, starting at 0.
- R5: The lookup is combinational. Every valid entry is compared in the same cycle, so earlier entries still hit after later captures.
- R6: A capture of an address that is already stored is ignored and does not use up a spare. The next new fault gets the next unused index.
- R7: A capture of a new address when all NUM_SPARES spares are in use sets `overflow`. The flag stays set until reset, and the existing mappings are unchanged.
- R8: A capture of an allocated spare s (`cap_spare`=1) assigns the next spare k. After that, a lookup of spare s, and of every address whose mapping ended at s, returns k. This applies through any number of chained spares.
- R9: A capture of a spare whose index has not yet been allocated is ignored and uses up no spare.
- R10: When the spare flag is set, only the low log2(NUM_SPARES) bits of the row field select the spare, and the upper bits are ignored. This holds for both capture and lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Record the capture address as faulty at the next edge |
| cap_spare | input | 1 | Capture address names a spare row |
| cap_row | input | ROW_W | Capture row address (spare index in low bits when cap_spare) |
| lk_spare | input | 1 | Lookup address names a spare row |
| lk_row | input | ROW_W | Lookup row address |
| remap_hit | output | 1 | Lookup matched a stored entry |
| out_spare | output | 1 | Output row is a spare row |
| out_row | output | ROW_W | Row to drive to the decoder (spare index when remapped) |
| overflow | output | 1 | Sticky: a new fault arrived with no spare left |

## Verification
The lookup path is tried with four kinds of address:
- Untouched regular rows and untouched spares, which must pass straight through and so separate a miss from a false hit.
- Freshly captured rows, which show the allocation order and the one-cycle capture latency.
- Repeated captures and captures of spares that are not yet allocated, which must leave the allocation pointer alone. A later fault shows this by getting the expected index.
- Chains of faulty spares, looked up from both the original regular row and each spare in the chain. This includes spare addresses with junk in the upper bits, to show that all of them end on the last spare.

Filling every spare and then capturing more rows shows the difference between a full table and a sticky overflow.

// File: rtl/srm_pkg.sv
package srm_pkg;

    localparam int SRM_ROW_W_DEF  = 10;
    localparam int SRM_SPARES_DEF = 8;

    // Width of a spare index for a given spare count
    function automatic int spare_idx_w(input int n_spares);
        return (n_spares <= 1) ? 1 : $clog2(n_spares);
    endfunction

endpackage

// File: rtl/srm_match.sv
// Parallel compare of one key against every valid table entry
module srm_match #(
    parameter int KEY_W = 11,
    parameter int N     = 8
) (
    input  logic [KEY_W-1:0]        key_i,
    input  logic [N-1:0][KEY_W-1:0] tbl_i,
    input  logic [N-1:0]            vld_i,
    output logic [N-1:0]            hit_o
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_o[g] = vld_i[g] && (tbl_i[g] == key_i);
    end

endmodule

// File: rtl/srm_pick.sv
// One-hot select of a target index, OR-reduced
module srm_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]         sel_i,
    input  logic [N-1:0][IW-1:0] tgt_i,
    output logic                 any_o,
    output logic [IW-1:0]        val_o
);

    always_comb begin
        val_o = '0;
        for (int e = 0; e < N; e++) begin
            if (sel_i[e]) begin
                val_o = val_o | tgt_i[e];
            end
        end
        any_o = |sel_i;
    end

endmodule

// File: rtl/srm_remap.sv
module srm_remap
    import srm_pkg::*;
#(
    parameter int ROW_W      = SRM_ROW_W_DEF,
    parameter int NUM_SPARES = SRM_SPARES_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             cap_spare,
    input  logic [ROW_W-1:0] cap_row,
    input  logic             lk_spare,
    input  logic [ROW_W-1:0] lk_row,
    output logic             remap_hit,
    output logic             out_spare,
    output logic [ROW_W-1:0] out_row,
    output logic             overflow
);

    localparam int IW    = spare_idx_w(NUM_SPARES);
    localparam int KEY_W = ROW_W + 1;
    localparam int CNT_W = IW + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_SPARES);

    typedef struct packed {
        logic [NUM_SPARES-1:0]            vld;
        logic [NUM_SPARES-1:0][KEY_W-1:0] key;
        logic [NUM_SPARES-1:0][IW-1:0]    tgt;
        logic [CNT_W-1:0]                 ptr;
        logic                             ovf;
    } state_t;

    state_t st_d, st_q;

    // Spare addresses keep only the index bits; the rest are zeroed
    function automatic logic [KEY_W-1:0] make_key(input logic spare, input logic [ROW_W-1:0] row);
        logic [KEY_W-1:0] k;
        if (spare) begin
            k = '0;
            k[KEY_W-1] = 1'b1;
            k[IW-1:0]  = row[IW-1:0];
        end else begin
            k = {1'b0, row};
        end
        return k;
    endfunction

    logic [KEY_W-1:0]      cap_key_d, lk_key_d;
    logic [NUM_SPARES-1:0] cap_hits_d, lk_hits_d;
    logic                  cap_dup_d, lk_any_d;
    logic [IW-1:0]         lk_tgt_d, cap_idx_d, cap_sel_d;
    logic [IW-1:0]         slot_d;
    logic                  cap_new_d;

    assign cap_key_d = make_key(cap_spare, cap_row);
    assign lk_key_d  = make_key(lk_spare, lk_row);
    assign cap_idx_d = cap_row[IW-1:0];

    srm_match #(.KEY_W(KEY_W), .N(NUM_SPARES)) i_cap_match (
        .key_i (cap_key_d),
        .tbl_i (st_q.key),
        .vld_i (st_q.vld),
        .hit_o (cap_hits_d)
    );

    srm_match #(.KEY_W(KEY_W), .N(NUM_SPARES)) i_lk_match (
        .key_i (lk_key_d),
        .tbl_i (st_q.key),
        .vld_i (st_q.vld),
        .hit_o (lk_hits_d)
    );

    srm_pick #(.N(NUM_SPARES), .IW(IW)) i_cap_pick (
        .sel_i (cap_hits_d),
        .tgt_i (st_q.tgt),
        .any_o (cap_dup_d),
        .val_o (cap_sel_d)
    );

    srm_pick #(.N(NUM_SPARES), .IW(IW)) i_lk_pick (
        .sel_i (lk_hits_d),
        .tgt_i (st_q.tgt),
        .any_o (lk_any_d),
        .val_o (lk_tgt_d)
    );

    always_comb begin
        st_d      = st_q;
        slot_d    = st_q.ptr[IW-1:0];
        cap_new_d = cap_en && !cap_dup_d
                    && !(cap_spare && ({1'b0, cap_idx_d} >= st_q.ptr));
        if (cap_new_d) begin
            if (st_q.ptr == FULL) begin
                st_d.ovf = 1'b1;
            end else begin
                // Everything that ended on the failed spare moves to the new one
                for (int e = 0; e < NUM_SPARES; e++) begin
                    if (cap_spare && st_q.vld[e] && (st_q.tgt[e] == cap_idx_d)) begin
                        st_d.tgt[e] = slot_d;
                    end
                end
                st_d.vld[slot_d] = 1'b1;
                st_d.key[slot_d] = cap_key_d;
                st_d.tgt[slot_d] = slot_d;
                st_d.ptr         = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign remap_hit = lk_any_d;
    assign out_spare = lk_any_d | lk_spare;
    assign out_row   = lk_any_d ? ROW_W'(lk_tgt_d) : lk_row;
    assign overflow  = st_q.ovf;

    // cap_sel_d is the duplicate's current target; only its presence matters
    logic unused_sel;
    assign unused_sel = ^cap_sel_d;

endmodule

// File: rtl/srm_remap_chk.sv
module srm_remap_chk #(
    parameter int ROW_W      = 10,
    parameter int NUM_SPARES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_en,
    input logic             lk_spare,
    input logic [ROW_W-1:0] lk_row,
    input logic             remap_hit,
    input logic             out_spare,
    input logic [ROW_W-1:0] out_row,
    input logic             overflow
);

    // R2
    miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !remap_hit |-> (out_row == lk_row) && (out_spare == lk_spare));

    // R3
    hit_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_hit |-> out_spare && (out_row < ROW_W'(NUM_SPARES)));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R7
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(cap_en));

endmodule

bind srm_remap srm_remap_chk #(.ROW_W(ROW_W), .NUM_SPARES(NUM_SPARES)) i_srm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .lk_spare  (lk_spare),
    .lk_row    (lk_row),
    .remap_hit (remap_hit),
    .out_spare (out_spare),
    .out_row   (out_row),
    .overflow  (overflow)
);

// File: tb/test_srm_remap.sv
module test_srm_remap;

    localparam int ROW_W = 10;
    localparam int NSP   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cap_en = 1'b0;
    logic             cap_spare = 1'b0;
    logic [ROW_W-1:0] cap_row = '0;
    logic             lk_spare = 1'b0;
    logic [ROW_W-1:0] lk_row = '0;
    logic             remap_hit, out_spare, overflow;
    logic [ROW_W-1:0] out_row;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    srm_remap #(.ROW_W(ROW_W), .NUM_SPARES(NSP)) i_srm_remap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_spare (cap_spare),
        .cap_row   (cap_row),
        .lk_spare  (lk_spare),
        .lk_row    (lk_row),
        .remap_hit (remap_hit),
        .out_spare (out_spare),
        .out_row   (out_row),
        .overflow  (overflow)
    );

    // {req[3:0], op, spare, row[9:0], exp_hit, exp_spare, exp_row[9:0], exp_ovf}
    // op 1 = capture (only exp_ovf checked), op 0 = lookup
    localparam int NV = 23;
    localparam logic [28:0] VEC [NV] = '{
        {4'd1,  1'b0, 1'b0, 10'd5,   1'b0, 1'b0, 10'd5,   1'b0}, // R1 R2 regular miss
        {4'd2,  1'b0, 1'b1, 10'd3,   1'b0, 1'b1, 10'd3,   1'b0}, // R2 spare miss
        {4'd3,  1'b1, 1'b0, 10'd100, 1'b0, 1'b0, 10'd0,   1'b0}, // R3 capture
        {4'd3,  1'b0, 1'b0, 10'd100, 1'b1, 1'b1, 10'd0,   1'b0}, // R3 -> spare 0
        {4'd4,  1'b1, 1'b0, 10'd200, 1'b0, 1'b0, 10'd0,   1'b0}, // R4
        {4'd4,  1'b0, 1'b0, 10'd200, 1'b1, 1'b1, 10'd1,   1'b0}, // R4 -> spare 1
        {4'd5,  1'b0, 1'b0, 10'd100, 1'b1, 1'b1, 10'd0,   1'b0}, // R5 old entry
        {4'd6,  1'b1, 1'b0, 10'd100, 1'b0, 1'b0, 10'd0,   1'b0}, // R6 duplicate
        {4'd6,  1'b1, 1'b0, 10'd300, 1'b0, 1'b0, 10'd0,   1'b0}, // R6
        {4'd6,  1'b0, 1'b0, 10'd300, 1'b1, 1'b1, 10'd2,   1'b0}, // R6 -> spare 2
        {4'd8,  1'b1, 1'b1, 10'd1,   1'b0, 1'b0, 10'd0,   1'b0}, // R8 spare 1 bad
        {4'd8,  1'b0, 1'b0, 10'd200, 1'b1, 1'b1, 10'd3,   1'b0}, // R8
        {4'd8,  1'b0, 1'b1, 10'd1,   1'b1, 1'b1, 10'd3,   1'b0}, // R8
        {4'd2,  1'b0, 1'b1, 10'd0,   1'b0, 1'b1, 10'd0,   1'b0}, // R2 good spare
        {4'd8,  1'b1, 1'b1, 10'd3,   1'b0, 1'b0, 10'd0,   1'b0}, // R8 spare 3 bad
        {4'd8,  1'b0, 1'b0, 10'd200, 1'b1, 1'b1, 10'd4,   1'b0}, // R8 chain
        {4'd8,  1'b0, 1'b1, 10'd1,   1'b1, 1'b1, 10'd4,   1'b0}, // R8 chain
        {4'd8,  1'b0, 1'b1, 10'd3,   1'b1, 1'b1, 10'd4,   1'b0}, // R8
        {4'd9,  1'b1, 1'b1, 10'd6,   1'b0, 1'b0, 10'd0,   1'b0}, // R9 unallocated
        {4'd9,  1'b0, 1'b1, 10'd6,   1'b0, 1'b1, 10'd6,   1'b0}, // R9
        {4'd10, 1'b0, 1'b1, 10'h3C1, 1'b1, 1'b1, 10'd4,   1'b0}, // R10 upper bits
        {4'd9,  1'b1, 1'b0, 10'd400, 1'b0, 1'b0, 10'd0,   1'b0}, // R9
        {4'd9,  1'b0, 1'b0, 10'd400, 1'b1, 1'b1, 10'd5,   1'b0}  // R9 -> spare 5
    };

    task automatic chk(input int req, input string what, input logic [15:0] got,
                       input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic do_cap(input logic sp, input logic [ROW_W-1:0] row);
        @(negedge clk);
        cap_en = 1'b1; cap_spare = sp; cap_row = row;
        @(negedge clk);
        cap_en = 1'b0;
    endtask

    task automatic look(input int req, input logic sp, input logic [ROW_W-1:0] row,
                        input logic eh, input logic es, input logic [ROW_W-1:0] er);
        @(negedge clk);
        lk_spare = sp; lk_row = row;
        #2;
        chk(req, "hit", 16'(remap_hit), 16'(eh));
        chk(req, "spare", 16'(out_spare), 16'(es));
        chk(req, "row", 16'(out_row), 16'(er));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R0 watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(1, "ovf in reset", 16'(overflow), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, "ovf after reset", 16'(overflow), 16'd0);

        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = VEC[i];
            if (v[24]) begin
                do_cap(v[23], v[22:13]);
                #2;
                chk(int'(v[28:25]), "ovf", 16'(overflow), 16'(v[0]));
            end else begin
                look(int'(v[28:25]), v[23], v[22:13], v[12], v[11], v[10:1]);
                chk(int'(v[28:25]), "ovf", 16'(overflow), 16'(v[0]));
            end
        end

        // R7 fill remaining spares then overflow
        do_cap(1'b0, 10'd500);
        do_cap(1'b0, 10'd600);
        look(5, 1'b0, 10'd600, 1'b1, 1'b1, 10'd7);
        #1 chk(7, "ovf when full", 16'(overflow), 16'd0);
        do_cap(1'b0, 10'd700);
        #2 chk(7, "ovf set", 16'(overflow), 16'd1);
        look(7, 1'b0, 10'd700, 1'b0, 1'b0, 10'd700);
        look(7, 1'b0, 10'd100, 1'b1, 1'b1, 10'd0);
        look(5, 1'b0, 10'd500, 1'b1, 1'b1, 10'd6);
        do_cap(1'b0, 10'd800);
        repeat (3) @(negedge clk);
        chk(7, "ovf sticky", 16'(overflow), 16'd1);

        // R1 reset clears everything
        rst_n = 1'b0;
        #2 chk(1, "ovf cleared", 16'(overflow), 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        look(1, 1'b0, 10'd100, 1'b0, 1'b0, 10'd100);
        look(1, 1'b1, 10'd4, 1'b0, 1'b1, 10'd4);

        // R3 capture is not visible in its own cycle
        @(negedge clk);
        cap_en = 1'b1; cap_spare = 1'b0; cap_row = 10'd900;
        lk_spare = 1'b0; lk_row = 10'd900;
        #2 chk(3, "same-cycle miss", 16'(remap_hit), 16'd0);
        @(negedge clk);
        cap_en = 1'b0;
        #2 chk(3, "next-cycle hit", 16'(remap_hit), 16'd1);
        chk(4, "first after reset", 16'(out_row), 16'd0);

        // R10 capture with junk upper bits names spare 0
        do_cap(1'b1, 10'h2F8);
        look(10, 1'b1, 10'd0, 1'b1, 1'b1, 10'd1);
        look(10, 1'b0, 10'd900, 1'b1, 1'b1, 10'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule